// File: doc/BRIEF.md
# Snooping MESI Coherency Controller

This block holds the four-state coherency tag (Modified, Exclusive, Shared, Invalid) for a small set of 64-byte lines. It serves two request streams. The processor side issues reads, reads with intent to modify, and write hits. The system side delivers snoops taken from a shared address bus. One state entry covers one 64-byte coherency unit. The line index arrives already resolved, because tag matching is done elsewhere.

For each snoop the block returns a registered coherency response one cycle later on a separate response port. It also reports the state the line holds after the snoop. When the line is held Modified or Shared, it raises a strobe asking the data path to supply the line cache-to-cache. Snoops are paced: after one is accepted, a snoop in the very next cycle is answered with retry. Each snoop carries an even-parity bit. A parity failure blocks the state change and sets a sticky machine-check flag.

A query port reads the state of any line combinationally, so the surrounding logic can inspect a line.

Top module: `mesi_coh_ctrl`

## Requirements
- R1: After reset every line reads Invalid (2'b00), and `rsp_valid_o`, `intv_o` and `mchk_o` are low. State encoding: I=2'b00, S=2'b01, E=2'b10, M=2'b11.
- R2: An accepted snoop gets its response with `rsp_valid_o` high exactly one cycle after it is presented. The code depends on the prior state of the line: Invalid gives 2'b00 (null), Shared or Exclusive gives 2'b01 (shared), and Modified gives 2'b10 (modified-intervention).
- R3: `intv_o` is raised together with the response when an accepted snoop hits a line held Modified or Shared. It stays low for Exclusive and Invalid, and for retried or parity-failed snoops.
- R4: A snoop read (`snp_rwitm_i`=0) moves a Modified or Exclusive line to Shared and leaves Shared and Invalid unchanged. `nxt_state_o` reports the resulting state.
- R5: A snoop read-with-intent-to-modify (`snp_rwitm_i`=1) moves any line to Invalid, and `nxt_state_o` reports Invalid.
- R6: A snoop presented in the cycle right after an accepted snoop is answered with 2'b11 (retry), without intervention and without a state change. A snoop one cycle later is accepted again.
- R7: A snoop is checked for even parity over {`snp_rwitm_i`, `snp_idx_i`, `snp_par_i`}. A failure gives response 2'b11, leaves the line unchanged, and sets `mchk_o`, which stays high until reset.
- R8: Processor read (`cpu_op_i`=2'b00) on an Invalid line fills Exclusive when `cpu_shared_i` is low and Shared when it is high. A read of a valid line leaves it unchanged.
- R9: Processor write hit (`cpu_op_i`=2'b10) moves Shared or Exclusive to Modified, keeps Modified, and leaves an Invalid line Invalid.
- R10: Processor read-with-intent-to-modify (`cpu_op_i`=2'b01) moves the line to Modified from any state.
- R11: When an accepted snoop and a processor request target the same line in the same cycle, the snoop update wins and the processor request is dropped. Requests on different lines both take effect.
- R12: Processor op code 2'b11 changes no line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cpu_valid_i | input | 1 | Processor request present |
| cpu_op_i | input | 2 | 00 read, 01 read-intent-modify, 10 write hit, 11 no-op |
| cpu_idx_i | input | IDX_W | Line addressed by the processor |
| cpu_shared_i | input | 1 | Combined bus response for a fill reported shared |
| snp_valid_i | input | 1 | Snoop present on the system bus |
| snp_rwitm_i | input | 1 | 0 snoop read, 1 snoop read-intent-modify |
| snp_idx_i | input | IDX_W | Line addressed by the snoop |
| snp_par_i | input | 1 | Even parity bit over op and index |
| qry_idx_i | input | IDX_W | Line to inspect |
| qry_state_o | output | 2 | State of the inspected line |
| rsp_valid_o | output | 1 | Response present |
| rsp_o | output | 2 | Coherency response code |
| intv_o | output | 1 | Cache-to-cache supply request |
| nxt_state_o | output | 2 | State of the snooped line after the snoop |
| mchk_o | output | 1 | Sticky machine-check flag |

## Verification
Some properties are checked in every cycle. No two accepted snoop responses are ever adjacent. Intervention only accompanies a shared or modified response, and a modified response always intervenes. An accepted read-intent-modify snoop always reports Invalid. The machine-check flag never falls without reset. The snoop and processor write ports never write the same line together. Other behaviours depend on the history of a line and can only be shown by the bench scenarios: the exact transition from each prior state, the choice between Exclusive and Shared on a fill, the no-update effect of retry and parity failure, and the loss of a colliding processor request.

// File: rtl/mesi_coh_pkg.sv
package mesi_coh_pkg;
  typedef enum logic [1:0] {
    ST_I = 2'b00,
    ST_S = 2'b01,
    ST_E = 2'b10,
    ST_M = 2'b11
  } line_st_e;

  typedef enum logic [1:0] {
    RSP_NULL  = 2'b00,
    RSP_SHR   = 2'b01,
    RSP_MOD   = 2'b10,
    RSP_RETRY = 2'b11
  } rsp_e;

  typedef enum logic [1:0] {
    CPU_RD    = 2'b00,
    CPU_RWITM = 2'b01,
    CPU_WR    = 2'b10,
    CPU_NOP   = 2'b11
  } cpu_op_e;
endpackage

// File: rtl/mesi_snoop_pacer.sv
module mesi_snoop_pacer #(
  parameter int unsigned IDX_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             snp_valid_i,
  input  logic             snp_rwitm_i,
  input  logic [IDX_W-1:0] snp_idx_i,
  input  logic             snp_par_i,
  output logic             accept_o,
  output logic             retry_o,
  output logic             perr_o
);
  logic busy_q;
  logic slot_free;
  logic par_bad;

  assign slot_free = snp_valid_i && !busy_q;
  assign par_bad   = ^{snp_rwitm_i, snp_idx_i, snp_par_i};
  assign accept_o  = slot_free && !par_bad;
  assign perr_o    = slot_free && par_bad;
  assign retry_o   = snp_valid_i && busy_q;

  // an errored snoop still occupies its bus slot
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) busy_q <= 1'b0;
    else         busy_q <= slot_free;
  end

  a_r6_no_accept_when_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept_o |=> !accept_o);
endmodule

// File: rtl/mesi_next_state.sv
module mesi_next_state
  import mesi_coh_pkg::*;
(
  input  logic [1:0] snp_cur_i,
  input  logic       snp_rwitm_i,
  output logic [1:0] snp_nxt_o,
  output logic [1:0] snp_rsp_o,
  output logic       snp_intv_o,
  input  logic [1:0] cpu_cur_i,
  input  logic [1:0] cpu_op_i,
  input  logic       cpu_shared_i,
  output logic [1:0] cpu_nxt_o
);
  line_st_e s_cur, c_cur;
  assign s_cur = line_st_e'(snp_cur_i);
  assign c_cur = line_st_e'(cpu_cur_i);

  always_comb begin
    snp_nxt_o  = snp_cur_i;
    snp_rsp_o  = RSP_NULL;
    snp_intv_o = 1'b0;
    unique case (s_cur)
      ST_I: snp_rsp_o = RSP_NULL;
      ST_S: begin snp_rsp_o = RSP_SHR; snp_intv_o = 1'b1; end
      ST_E: snp_rsp_o = RSP_SHR;
      ST_M: begin snp_rsp_o = RSP_MOD; snp_intv_o = 1'b1; end
      default: ;
    endcase
    if (snp_rwitm_i)              snp_nxt_o = ST_I;
    else if (s_cur inside {ST_M, ST_E}) snp_nxt_o = ST_S;
  end

  always_comb begin
    cpu_nxt_o = cpu_cur_i;
    unique case (cpu_op_e'(cpu_op_i))
      CPU_RD:    if (c_cur == ST_I) cpu_nxt_o = cpu_shared_i ? ST_S : ST_E;
      CPU_RWITM: cpu_nxt_o = ST_M;
      CPU_WR:    if (c_cur != ST_I) cpu_nxt_o = ST_M;
      CPU_NOP:   ;
      default:   ;
    endcase
  end
endmodule

// File: rtl/mesi_state_array.sv
module mesi_state_array
  import mesi_coh_pkg::*;
#(
  parameter int unsigned LINES = 16,
  parameter int unsigned IDX_W = $clog2(LINES)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sw_en_i,
  input  logic [IDX_W-1:0] sw_idx_i,
  input  logic [1:0]       sw_st_i,
  input  logic             cw_en_i,
  input  logic [IDX_W-1:0] cw_idx_i,
  input  logic [1:0]       cw_st_i,
  input  logic [IDX_W-1:0] sr_idx_i,
  output logic [1:0]       sr_st_o,
  input  logic [IDX_W-1:0] cr_idx_i,
  output logic [1:0]       cr_st_o,
  input  logic [IDX_W-1:0] qr_idx_i,
  output logic [1:0]       qr_st_o
);
  logic [1:0] st_q [LINES];

  for (genvar g = 0; g < LINES; g++) begin : g_line
    logic hit_s, hit_c;
    assign hit_s = sw_en_i && (sw_idx_i == IDX_W'(g));
    assign hit_c = cw_en_i && (cw_idx_i == IDX_W'(g));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)    st_q[g] <= ST_I;
      else if (hit_s) st_q[g] <= sw_st_i;
      else if (hit_c) st_q[g] <= cw_st_i;
    end
  end

  assign sr_st_o = st_q[sr_idx_i];
  assign cr_st_o = st_q[cr_idx_i];
  assign qr_st_o = st_q[qr_idx_i];

  a_r11_no_dual_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(sw_en_i && cw_en_i && (sw_idx_i == cw_idx_i)));
endmodule

// File: rtl/mesi_coh_ctrl.sv
module mesi_coh_ctrl
  import mesi_coh_pkg::*;
#(
  parameter int unsigned LINES = 16,
  localparam int unsigned IDX_W = $clog2(LINES)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cpu_valid_i,
  input  logic [1:0]       cpu_op_i,
  input  logic [IDX_W-1:0] cpu_idx_i,
  input  logic             cpu_shared_i,
  input  logic             snp_valid_i,
  input  logic             snp_rwitm_i,
  input  logic [IDX_W-1:0] snp_idx_i,
  input  logic             snp_par_i,
  input  logic [IDX_W-1:0] qry_idx_i,
  output logic [1:0]       qry_state_o,
  output logic             rsp_valid_o,
  output logic [1:0]       rsp_o,
  output logic             intv_o,
  output logic [1:0]       nxt_state_o,
  output logic             mchk_o
);
  logic       acc, rty, perr;
  logic [1:0] snp_cur, snp_nxt, snp_rsp, cpu_cur, cpu_nxt;
  logic       snp_intv, cpu_we;

  mesi_snoop_pacer #(.IDX_W(IDX_W)) i_pacer (
    .clk_i, .rst_ni, .snp_valid_i, .snp_rwitm_i, .snp_idx_i, .snp_par_i,
    .accept_o(acc), .retry_o(rty), .perr_o(perr)
  );

  mesi_next_state i_next (
    .snp_cur_i(snp_cur), .snp_rwitm_i, .snp_nxt_o(snp_nxt),
    .snp_rsp_o(snp_rsp), .snp_intv_o(snp_intv),
    .cpu_cur_i(cpu_cur), .cpu_op_i, .cpu_shared_i, .cpu_nxt_o(cpu_nxt)
  );

  // snoop owns the line on a same-cycle collision
  assign cpu_we = cpu_valid_i && (cpu_op_i != CPU_NOP) &&
                  !(acc && (snp_idx_i == cpu_idx_i));

  mesi_state_array #(.LINES(LINES), .IDX_W(IDX_W)) i_array (
    .clk_i, .rst_ni,
    .sw_en_i(acc), .sw_idx_i(snp_idx_i), .sw_st_i(snp_nxt),
    .cw_en_i(cpu_we), .cw_idx_i(cpu_idx_i), .cw_st_i(cpu_nxt),
    .sr_idx_i(snp_idx_i), .sr_st_o(snp_cur),
    .cr_idx_i(cpu_idx_i), .cr_st_o(cpu_cur),
    .qr_idx_i(qry_idx_i), .qr_st_o(qry_state_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o <= 1'b0;
      rsp_o       <= RSP_NULL;
      intv_o      <= 1'b0;
      nxt_state_o <= ST_I;
      mchk_o      <= 1'b0;
    end else begin
      rsp_valid_o <= snp_valid_i;
      rsp_o       <= acc ? snp_rsp : RSP_RETRY;
      intv_o      <= acc && snp_intv;
      nxt_state_o <= acc ? snp_nxt : snp_cur;
      if (perr) mchk_o <= 1'b1;
    end
  end

  a_r6_no_adjacent_grants: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && rsp_o != RSP_RETRY) |=> !(rsp_valid_o && rsp_o != RSP_RETRY));
  a_r3_intv_with_hit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    intv_o |-> (rsp_valid_o && (rsp_o == RSP_SHR || rsp_o == RSP_MOD)));
  a_r2_mod_intervenes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && rsp_o == RSP_MOD) |-> intv_o);
  a_r5_rwitm_invalid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc && snp_rwitm_i) |=> (nxt_state_o == ST_I));
  a_r7_mchk_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mchk_o |=> mchk_o);
endmodule

// File: tb/test_mesi_coh_ctrl.sv
module test_mesi_coh_ctrl;
  localparam int LINES = 16;
  localparam int IDX_W = 4;
  localparam logic [1:0] I = 2'b00, S = 2'b01, E = 2'b10, M = 2'b11;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cpu_valid = 0, cpu_shared = 0, snp_valid = 0, snp_rwitm = 0, snp_par = 0;
  logic [1:0] cpu_op = 2'b11;
  logic [IDX_W-1:0] cpu_idx = '0, snp_idx = '0, qry_idx = '0;
  logic [1:0] qry_state, rsp, nxt;
  logic rsp_valid, intv, mchk;
  int checks = 0, errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  mesi_coh_ctrl #(.LINES(LINES)) i_mesi_coh_ctrl (
    .clk_i(clk), .rst_ni(rst_n),
    .cpu_valid_i(cpu_valid), .cpu_op_i(cpu_op), .cpu_idx_i(cpu_idx), .cpu_shared_i(cpu_shared),
    .snp_valid_i(snp_valid), .snp_rwitm_i(snp_rwitm), .snp_idx_i(snp_idx), .snp_par_i(snp_par),
    .qry_idx_i(qry_idx), .qry_state_o(qry_state),
    .rsp_valid_o(rsp_valid), .rsp_o(rsp), .intv_o(intv), .nxt_state_o(nxt), .mchk_o(mchk)
  );

  task automatic chk(input string req, input logic [1:0] act, input logic [1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic qry(input int idx, output logic [1:0] st);
    qry_idx = IDX_W'(idx);
    #1 st = qry_state;
  endtask

  task automatic drive_snp(input logic rw, input int idx, input logic badp);
    snp_valid = 1; snp_rwitm = rw; snp_idx = IDX_W'(idx);
    snp_par = ^{rw, IDX_W'(idx)} ^ badp;
  endtask

  task automatic snoop(input logic rw, input int idx, input logic badp,
                       output logic rv, output logic [1:0] r, output logic iv, output logic [1:0] ns);
    @(negedge clk); drive_snp(rw, idx, badp);
    @(negedge clk); snp_valid = 0;
    rv = rsp_valid; r = rsp; iv = intv; ns = nxt;
  endtask

  task automatic cpu(input logic [1:0] op, input int idx, input logic shr);
    @(negedge clk); cpu_valid = 1; cpu_op = op; cpu_idx = IDX_W'(idx); cpu_shared = shr;
    @(negedge clk); cpu_valid = 0; cpu_op = 2'b11;
  endtask

  task automatic set_line(input int idx, input logic [1:0] st);
    logic rv, iv; logic [1:0] r, ns;
    snoop(1'b1, idx, 1'b0, rv, r, iv, ns);
    if (st == M) cpu(2'b01, idx, 1'b0);
    else if (st == E) cpu(2'b00, idx, 1'b0);
    else if (st == S) cpu(2'b00, idx, 1'b1);
  endtask

  task automatic t_reset();
    logic [1:0] st;
    for (int k = 0; k < LINES; k += 5) begin qry(k, st); chk("R1 line invalid", st, I); end
    chk("R1 rsp_valid low", {1'b0, rsp_valid}, 2'b00);
    chk("R1 intv low", {1'b0, intv}, 2'b00);
    chk("R1 mchk low", {1'b0, mchk}, 2'b00);
  endtask

  task automatic t_cpu();
    logic [1:0] st;
    cpu(2'b00, 1, 1'b0); qry(1, st); chk("R8 fill exclusive", st, E);
    cpu(2'b00, 2, 1'b1); qry(2, st); chk("R8 fill shared", st, S);
    cpu(2'b00, 1, 1'b1); qry(1, st); chk("R8 read hit unchanged", st, E);
    cpu(2'b10, 2, 1'b0); qry(2, st); chk("R9 write S->M", st, M);
    cpu(2'b10, 1, 1'b0); qry(1, st); chk("R9 write E->M", st, M);
    cpu(2'b10, 1, 1'b0); qry(1, st); chk("R9 write M stays", st, M);
    cpu(2'b10, 7, 1'b0); qry(7, st); chk("R9 write on I stays I", st, I);
    cpu(2'b01, 8, 1'b0); qry(8, st); chk("R10 rwitm I->M", st, M);
    set_line(9, S); cpu(2'b01, 9, 1'b0); qry(9, st); chk("R10 rwitm S->M", st, M);
    cpu(2'b00, 8, 1'b1); qry(8, st); chk("R8 read hit M unchanged", st, M);
  endtask

  task automatic t_snoop_read();
    logic rv, iv; logic [1:0] r, ns, st;
    logic [1:0] pre [4] = '{I, S, E, M};
    logic [1:0] ersp [4] = '{2'b00, 2'b01, 2'b01, 2'b10};
    logic [1:0] ens [4] = '{I, S, S, S};
    logic eiv [4] = '{1'b0, 1'b1, 1'b0, 1'b1};
    for (int k = 0; k < 4; k++) begin
      set_line(10, pre[k]);
      snoop(1'b0, 10, 1'b0, rv, r, iv, ns);
      chk("R2 rsp_valid", {1'b0, rv}, 2'b01);
      chk("R2 response code", r, ersp[k]);
      chk("R3 intervention", {1'b0, iv}, {1'b0, eiv[k]});
      chk("R4 reported next state", ns, ens[k]);
      qry(10, st); chk("R4 stored state", st, ens[k]);
    end
  endtask

  task automatic t_snoop_rwitm();
    logic rv, iv; logic [1:0] r, ns, st;
    logic [1:0] pre [3] = '{S, E, M};
    for (int k = 0; k < 3; k++) begin
      set_line(11, pre[k]);
      snoop(1'b1, 11, 1'b0, rv, r, iv, ns);
      chk("R5 reported invalid", ns, I);
      qry(11, st); chk("R5 stored invalid", st, I);
    end
    chk("R3 intv on modified rwitm", {1'b0, iv}, 2'b01);
    chk("R2 rwitm modified response", r, 2'b10);
  endtask

  task automatic t_pacing();
    logic [1:0] st;
    set_line(12, M); set_line(13, M);
    @(negedge clk); drive_snp(1'b0, 12, 1'b0);
    @(negedge clk); drive_snp(1'b1, 13, 1'b0);
    chk("R6 first accepted", rsp, 2'b10);
    @(negedge clk); snp_valid = 0;
    chk("R6 second retried", rsp, 2'b11);
    chk("R6 retry no intv", {1'b0, intv}, 2'b00);
    qry(13, st); chk("R6 retry leaves line", st, M);
    @(negedge clk); drive_snp(1'b1, 13, 1'b0);
    @(negedge clk); snp_valid = 0;
    chk("R6 reissue accepted", rsp, 2'b10);
    qry(13, st); chk("R6 reissue applied", st, I);
  endtask

  task automatic t_parity();
    logic rv, iv; logic [1:0] r, ns, st;
    set_line(6, M);
    snoop(1'b1, 6, 1'b1, rv, r, iv, ns);
    chk("R7 parity response retry", r, 2'b11);
    chk("R7 parity no intv", {1'b0, iv}, 2'b00);
    chk("R7 mchk set", {1'b0, mchk}, 2'b01);
    qry(6, st); chk("R7 line unchanged", st, M);
    snoop(1'b0, 6, 1'b0, rv, r, iv, ns);
    chk("R7 mchk sticky", {1'b0, mchk}, 2'b01);
    chk("R7 good snoop after error", r, 2'b10);
  endtask

  task automatic t_conflict();
    logic [1:0] st;
    set_line(3, E);
    @(negedge clk); drive_snp(1'b0, 3, 1'b0);
    cpu_valid = 1; cpu_op = 2'b10; cpu_idx = 3;
    @(negedge clk); snp_valid = 0; cpu_valid = 0; cpu_op = 2'b11;
    qry(3, st); chk("R11 snoop wins same line", st, S);
    set_line(4, E); set_line(5, E);
    @(negedge clk); drive_snp(1'b1, 5, 1'b0);
    cpu_valid = 1; cpu_op = 2'b10; cpu_idx = 4;
    @(negedge clk); snp_valid = 0; cpu_valid = 0; cpu_op = 2'b11;
    qry(4, st); chk("R11 cpu other line applied", st, M);
    qry(5, st); chk("R11 snoop other line applied", st, I);
  endtask

  task automatic t_nop();
    logic [1:0] st;
    set_line(14, S);
    cpu(2'b11, 14, 1'b0); qry(14, st); chk("R12 nop on shared", st, S);
    cpu(2'b11, 15, 1'b0); qry(15, st); chk("R12 nop on invalid", st, I);
  endtask

  initial begin
    #1;
    t_reset();
    #30 rst_n = 1;
    t_cpu();
    t_snoop_read();
    t_snoop_rwitm();
    t_pacing();
    t_conflict();
    t_nop();
    t_parity();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule